// File: doc/BRIEF.md
# Four-Channel Serial DAC Sweep Master

This block updates a four-output, 12-bit serial digital-to-analog converter from a bank of four sample codes. Each pulse on `tick` copies the code bank into the block and starts a sweep. A sweep sends one 32-bit write-and-update frame per output, in the order 0, 1, 2, 3. In broadcast mode it sends a single frame that loads every output at once. The serial link idles with its clock low. Data leaves most significant bit first and is set up while the clock is low. The returning line is read on the same system-clock edge that drops the serial clock, which gives a slow converter output the most time to settle.

The converter shifts back the command it received before, and the block records those 32 bits as an echo word. After the last frame of a sweep, a one-cycle `done` pulse marks the end, and `echo` then holds the word returned during that frame. After reset, the converter's active-low clear line is pulsed before any frame can start. The select and control lines of the other devices on the shared bus are held in their inactive levels. A tick that arrives during a sweep is dropped and sets a sticky overrun flag.

Top module: `dac_sweep_spi`

## Requirements
- R1: Outside a frame, `sck` is low and `dac_cs_n` is high. At all times `rom_cs_n`, `amp_cs_n` and `spare_ctl` are high, and `adc_conv` and `amp_shdn` are low.
- R2: `dac_clr_n` is low during reset and for CLR_LEN cycles after reset is released, then goes high. No frame starts and `busy` stays low during that time.
- R3: A frame is 32 bits sent MSB first as {8'h00, 4'b0011, addr[3:0], code[11:0], 4'b0000}.
- R4: A normal sweep sends four frames with addr = 0, 1, 2, 3 in that order. Frame i carries code `level[12*i +: 12]`.
- R5: If `bcast` is high on the accepted tick, the sweep is a single frame with addr 4'hF carrying `level[11:0]`.
- R6: The codes are captured on the accepted tick. Later changes to `level` do not alter the frames of that sweep.
- R7: One `sck` period lasts 2*HALF_DIV clock cycles, with HALF_DIV cycles low and then HALF_DIV high. `mosi` changes only while `sck` is low.
- R8: `miso` is sampled on the clock edge at which `sck` falls. The 32 sampled bits of a frame, first bit in the MSB, become `echo`.
- R9: `dac_cs_n` stays low for exactly 32 `sck` pulses per frame. Between frames of one sweep it stays high for GAP_LEN cycles.
- R10: `done` is a one-cycle pulse at the end of the sweep's last frame, with `busy` low in that cycle. `echo` then holds that frame's received word.
- R11: A tick while `busy` is high starts nothing. It sets `overrun`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe, one cycle |
| bcast | input | 1 | Send one all-outputs frame on this tick |
| level | input | 48 | Four 12-bit codes, output i in bits 12*i+11:12*i |
| miso | input | 1 | Serial data from the converter |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| dac_cs_n | output | 1 | Converter select, active low |
| dac_clr_n | output | 1 | Converter clear, active low |
| rom_cs_n | output | 1 | Flash select, held high |
| amp_cs_n | output | 1 | Amplifier select, held high |
| spare_ctl | output | 1 | Spare control line, held high |
| adc_conv | output | 1 | ADC convert strobe, held low |
| amp_shdn | output | 1 | Amplifier shutdown, held low |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished, one cycle |
| echo | output | 32 | Word received in the latest frame |
| overrun | output | 1 | Sticky: tick arrived while busy |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge. They also assume that `tick` and `level` change only between clock edges. `miso` may change at any time, because only the bench compares it against expected words. The bench drives every input on the falling clock edge. Its converter model changes `miso` only on falling `sck` edges and on the select's falling edge, which is the timing the sampling point is built for. Overrun is tested with a single tick placed in the middle of a sweep. Ticks never fall inside the clear window.

// File: rtl/dac_sweep_spi.sv
module dac_sweep_spi #(
  parameter int HALF_DIV = 10,
  parameter int CLR_LEN  = 4,
  parameter int GAP_LEN  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bcast,
  input  logic [47:0] level,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        dac_cs_n,
  output logic        dac_clr_n,
  output logic        rom_cs_n,
  output logic        amp_cs_n,
  output logic        spare_ctl,
  output logic        adc_conv,
  output logic        amp_shdn,
  output logic        busy,
  output logic        done,
  output logic [31:0] echo,
  output logic        overrun
);
  localparam int PW   = $clog2(2 * HALF_DIV);
  localparam int CMAX = (CLR_LEN > GAP_LEN) ? CLR_LEN : GAP_LEN;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_CLR, S_IDLE, S_SHIFT, S_GAP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] ph;
  logic [4:0]  nbit;
  logic [1:0]  ch;
  logic        all_q;
  logic [47:0] bank;
  logic [31:0] txw, rxw;
  logic        sck_q, done_q, ovr_q;
  logic [31:0] echo_q;

  function automatic logic [31:0] mk_frame(input logic [3:0] a, input logic [11:0] c);
    return {8'h00, 4'b0011, a, c, 4'b0000};
  endfunction

  assign sck       = sck_q;
  assign mosi      = txw[31];
  assign dac_cs_n  = (st != S_SHIFT);
  assign dac_clr_n = (st != S_CLR);
  assign rom_cs_n  = 1'b1;
  assign amp_cs_n  = 1'b1;
  assign spare_ctl = 1'b1;
  assign adc_conv  = 1'b0;
  assign amp_shdn  = 1'b0;
  assign busy      = (st == S_SHIFT) || (st == S_GAP);
  assign done      = done_q;
  assign echo      = echo_q;
  assign overrun   = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_CLR;
      cnt    <= '0;
      ph     <= '0;
      nbit   <= '0;
      ch     <= '0;
      all_q  <= 1'b0;
      bank   <= '0;
      txw    <= '0;
      rxw    <= '0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      echo_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick && busy) ovr_q <= 1'b1;
      case (st)
        S_CLR: begin
          if (cnt == CW'(CLR_LEN - 1)) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_IDLE: begin
          if (tick) begin
            bank  <= level;
            all_q <= bcast;
            ch    <= '0;
            ph    <= '0;
            nbit  <= '0;
            txw   <= mk_frame(bcast ? 4'hF : 4'h0, level[11:0]);
            st    <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (ph == PW'(HALF_DIV - 1)) sck_q <= 1'b1;
          if (ph == PW'(2 * HALF_DIV - 1)) begin
            ph    <= '0;
            sck_q <= 1'b0;
            rxw   <= {rxw[30:0], miso};
            txw   <= {txw[30:0], 1'b0};
            if (nbit == 5'd31) begin
              nbit   <= '0;
              echo_q <= {rxw[30:0], miso};
              if (all_q || ch == 2'd3) begin
                st     <= S_IDLE;
                done_q <= 1'b1;
              end else begin
                st  <= S_GAP;
                cnt <= '0;
                ch  <= ch + 1'b1;
              end
            end else begin
              nbit <= nbit + 1'b1;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == CW'(GAP_LEN - 1)) begin
            txw <= mk_frame({2'b00, ch}, bank[12*ch +: 12]);
            ph  <= '0;
            st  <= S_SHIFT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_CLR;
      endcase
    end
  end
endmodule

module dac_sweep_spi_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic mosi,
  input logic dac_cs_n,
  input logic dac_clr_n,
  input logic busy,
  input logic done,
  input logic overrun
);
  // R1
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> !sck);
  // R7
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  // R9
  select_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_cs_n) |-> busy);
  // R2
  clear_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_clr_n |-> (dac_cs_n && !busy));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind dac_sweep_spi dac_sweep_spi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .dac_cs_n(dac_cs_n),
  .dac_clr_n(dac_clr_n), .busy(busy), .done(done), .overrun(overrun)
);

// File: tb/dac_sweep_spi_test.sv
module dac_sweep_spi_test;
  localparam int HALF = 10;
  localparam int CLRN = 4;
  localparam int GAPN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic bcast = 1'b0;
  logic [47:0] level = '0;
  logic miso = 1'b0;
  logic sck, mosi, dac_cs_n, dac_clr_n, rom_cs_n, amp_cs_n, spare_ctl, adc_conv, amp_shdn;
  logic busy, done, overrun;
  logic [31:0] echo;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dac_sweep_spi uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bcast(bcast), .level(level), .miso(miso),
    .sck(sck), .mosi(mosi), .dac_cs_n(dac_cs_n), .dac_clr_n(dac_clr_n),
    .rom_cs_n(rom_cs_n), .amp_cs_n(amp_cs_n), .spare_ctl(spare_ctl),
    .adc_conv(adc_conv), .amp_shdn(amp_shdn), .busy(busy), .done(done),
    .echo(echo), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] frame_of(input logic [3:0] a, input logic [11:0] c);
    return {8'h00, 4'h3, a, c, 4'h0};
  endfunction

  // scoreboard
  logic [31:0] exp_q[$];
  logic [31:0] stored = 32'hA5C3_0F69;
  logic [31:0] txs, rxs, echo_exp;
  int          bits = 0;
  bit          in_frame = 0;
  int          done_cnt = 0;
  bit          prev_done = 0;

  always @(negedge dac_cs_n) begin
    if (rst_n) begin
      in_frame = 1;
      bits = 0;
      txs = stored;
      miso = txs[31];
    end
  end

  always @(negedge sck) begin
    if (!dac_cs_n) begin
      txs = {txs[30:0], 1'b0};
      miso = txs[31];
    end
  end

  always @(posedge sck) begin
    if (!dac_cs_n) begin
      rxs = {rxs[30:0], mosi};
      bits++;
    end
  end

  always @(posedge dac_cs_n) begin
    if (in_frame) begin
      in_frame = 0;
      chk("R9 sck pulses per frame", bits, 32);
      if (exp_q.size() == 0) begin
        chk("R11 unexpected frame", rxs, 32'hFFFF_FFFF);
      end else begin
        chk("R3/R4 frame word", rxs, exp_q.pop_front());
      end
      echo_exp = stored;
      stored = rxs;
    end
  end

  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      chk("R8/R10 echo at done", echo, echo_exp);
      chk("R10 busy low with done", {31'd0, busy}, 0);
      chk("R4 all frames sent at done", exp_q.size(), 0);
      if (prev_done) chk("R10 done one cycle", 1, 0);
    end
    prev_done = done;
  end

  task automatic start_sweep(input logic b, input logic [47:0] lv, input bit alter);
    @(negedge clk);
    while (busy) @(negedge clk);
    if (b) exp_q.push_back(frame_of(4'hF, lv[11:0]));
    else for (int i = 0; i < 4; i++) exp_q.push_back(frame_of(4'(i), lv[12*i +: 12]));
    level = lv;
    bcast = b;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    bcast = 1'b0;
    if (alter) level = ~lv;
  endtask

  task automatic wait_done();
    int d0;
    d0 = done_cnt;
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 R2 reset state
    chk("R1 cs idle", {31'd0, dac_cs_n}, 1);
    chk("R1 sck idle", {31'd0, sck}, 0);
    chk("R1 park lines", {27'd0, rom_cs_n, amp_cs_n, spare_ctl, adc_conv, amp_shdn}, 32'b11100);
    chk("R2 clear low in reset", {31'd0, dac_clr_n}, 0);
    chk("R10 idle flags", {29'd0, busy, done, overrun}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!dac_clr_n) begin
      if (!dac_cs_n || busy) chk("R2 no frame during clear", 1, 0);
      n++;
      @(negedge clk);
    end
    chk("R2 clear length", n, CLRN);

    // R4 several patterns
    start_sweep(1'b0, {12'hABC, 12'h789, 12'h456, 12'h123}, 0); wait_done();
    start_sweep(1'b0, '0, 0); wait_done();
    start_sweep(1'b0, {4{12'hFFF}}, 0); wait_done();
    // R5 broadcast
    start_sweep(1'b1, {12'h111, 12'h222, 12'h333, 12'hCCD}, 0); wait_done();
    // R6 snapshot
    start_sweep(1'b0, {12'h5A5, 12'h0F0, 12'hA5A, 12'h801}, 1); wait_done();
    chk("R11 no overrun yet", {31'd0, overrun}, 0);

    // R7 R9 timing
    start_sweep(1'b0, {12'hCCD, 12'h333, 12'hCCD, 12'h333}, 0);
    while (!sck) @(negedge clk);
    n = 0;
    while (sck) begin @(negedge clk); n++; end
    chk("R7 sck high half", n, HALF);
    while (!sck) begin @(negedge clk); n++; end
    chk("R7 sck period", n, 2 * HALF);
    while (!dac_cs_n) @(negedge clk);
    n = 0;
    while (dac_cs_n) begin @(negedge clk); n++; end
    chk("R9 gap between frames", n, GAPN);
    wait_done();

    // R11 overrun
    start_sweep(1'b0, {12'h010, 12'h020, 12'h030, 12'h040}, 0);
    repeat (100) @(negedge clk);
    level = {4{12'h999}};
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    wait_done();
    chk("R11 overrun set", {31'd0, overrun}, 1);
    start_sweep(1'b0, {12'h777, 12'h666, 12'h555, 12'h444}, 0); wait_done();
    repeat (20) @(negedge clk);
    chk("R11 overrun sticky", {31'd0, overrun}, 1);
    chk("R4 no stray frames", exp_q.size(), 0);
    chk("R10 done count", done_cnt, 8);
    chk("R1 idle after sweeps", {30'd0, dac_cs_n, sck}, 32'b10);
    summary();
  end
endmodule